// File: doc/BRIEF.md
# PHY Address Discovery Sequencer

This block finds the management address of an attached Ethernet PHY by driving a separate MDIO command engine. After a start pulse it reads the basic status register (register 1) of one candidate address at a time. It judges each returned value with a fixed validity test and stops at the first address that passes.

If the caller supplies a preferred address, that address is probed first. If the preferred address fails, or if none is given, the sequencer walks the whole 5-bit address space from 31 down to 0. Every command is preceded and followed by polling of the engine's idle flag. The number of polls is bounded, and an engine that stays busy aborts the search with its own error flag.

The outcome is reported with a one-cycle done pulse and three mutually exclusive flags: found, missing and timeout. The found address is held until the next start.

Top module: `phy_scan_seq`

## Requirements
- R1: While reset is high, and after it, `done`, `phy_found`, `phy_missing`, `mdio_timeout`, `phy_addr` and `cmd_rd` are all zero until a search is started.
- R2: Every read command is a one-cycle `cmd_rd` pulse with `cmd_reg` equal to 1. It is issued only in the cycle after `cmd_idle` was seen high by the sequencer.
- R3: A returned value is accepted only if it is not 16'hFFFF and has bits 12, 11 and 3 (mask 16'h1808) all set. A value missing any of them, such as 16'h1800, is rejected.
- R4: When `dflt_valid` is high at start, the first probe goes to `dflt_addr`. If it is accepted, the search ends after that single probe.
- R5: When there is no preferred address, or the preferred address is rejected, the addresses 31, 30, ... 0 are probed in that order. The search stops at the first accepted one, and no further command is issued.
- R6: If every probed address is rejected, `phy_missing` is raised with `done`, and `phy_found` and `phy_addr` stay zero.
- R7: If `cmd_idle` stays low for 200 consecutive polls, either before a command or after it, the search is aborted. `mdio_timeout` is raised with `done`, distinct from `phy_missing`.
- R8: `done` is high for exactly one cycle per search, with exactly one result flag set. The flags and `phy_addr` then hold until the next accepted start.
- R9: A `start` pulse that arrives while a search is running is ignored. It changes neither the probe order nor the result nor its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a search (taken only when not busy) |
| dflt_valid | input | 1 | A preferred address is supplied |
| dflt_addr | input | 5 | Preferred address |
| cmd_addr | output | 5 | PHY address of the current command |
| cmd_reg | output | 5 | Register number of the current command (always 1) |
| cmd_rd | output | 1 | One-cycle read request to the MDIO engine |
| cmd_rdata | input | 16 | Read data, valid when `cmd_idle` returns high |
| cmd_idle | input | 1 | MDIO engine ready / previous command complete |
| done | output | 1 | One-cycle end-of-search pulse |
| phy_found | output | 1 | An acceptable PHY was found |
| phy_missing | output | 1 | No address passed the test |
| mdio_timeout | output | 1 | The engine stayed busy too long |
| phy_addr | output | 5 | Address of the found PHY |

## Verification
Each probe takes three sequencer cycles plus the engine's busy time: one idle poll, one strobe cycle and one cycle to evaluate the returned data. With an engine that answers LAT cycles after the strobe, `done` therefore appears 1 + N*(LAT+3) sampled cycles after start is raised, where N is the number of probes. A timeout appears after 201 cycles when it happens before the first command, and after 203 cycles when it happens after the first strobe. The scoreboard stamps the cycle at which start is raised, predicts N from its own table of PHY register values, and compares the measured distance to `done` against that count. It also checks the ordered list of addresses seen on each strobe. All sampling happens on the falling clock edge, half a cycle after the registers update.

// File: rtl/phy_scan_pkg.sv
package phy_scan_pkg;

    localparam int PHY_AW   = 5;
    localparam int PHY_RW   = 5;
    localparam int PHY_DW   = 16;
    localparam logic [PHY_AW-1:0] TOP_ADDR = '1;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_PRE   = 2'd1,
        SQ_ISSUE = 2'd2,
        SQ_POST  = 2'd3
    } sq_state_t;

    typedef struct packed {
        logic              found;
        logic              missing;
        logic              timeout;
        logic [PHY_AW-1:0] addr;
    } scan_result_t;

    function automatic logic status_ok(input logic [PHY_DW-1:0] v,
                                       input logic [PHY_DW-1:0] need);
        return (v != '1) && ((v & need) == need);
    endfunction

endpackage

// File: rtl/phy_scan_poll_timer.sv
module phy_scan_poll_timer #(
    parameter int LIMIT = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic poll,
    input  logic idle,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] misses_q;
    logic          miss;

    assign miss   = poll && !idle;
    assign expire = miss && (misses_q == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || !miss || expire) begin
            misses_q <= '0;
        end else begin
            misses_q <= misses_q + 1'b1;
        end
    end
endmodule

// File: rtl/phy_scan_addr_gen.sv
module phy_scan_addr_gen
    import phy_scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              dflt_valid,
    input  logic [PHY_AW-1:0] dflt_addr,
    input  logic              advance,
    output logic [PHY_AW-1:0] addr,
    output logic              last_probe
);
    logic [PHY_AW-1:0] addr_q;
    logic              on_dflt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q    <= '0;
            on_dflt_q <= 1'b0;
        end else if (load) begin
            addr_q    <= dflt_valid ? dflt_addr : TOP_ADDR;
            on_dflt_q <= dflt_valid;
        end else if (advance) begin
            if (on_dflt_q) begin
                addr_q    <= TOP_ADDR;
                on_dflt_q <= 1'b0;
            end else begin
                addr_q <= addr_q - 1'b1;
            end
        end
    end

    assign addr       = addr_q;
    assign last_probe = !on_dflt_q && (addr_q == '0);
endmodule

// File: rtl/phy_scan_seq.sv
module phy_scan_seq
    import phy_scan_pkg::*;
#(
    parameter int                POLL_LIMIT = 200,
    parameter logic [PHY_RW-1:0] STATUS_REG = 5'd1,
    parameter logic [PHY_DW-1:0] CAP_MASK   = 16'h1808
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              dflt_valid,
    input  logic [PHY_AW-1:0] dflt_addr,
    output logic [PHY_AW-1:0] cmd_addr,
    output logic [PHY_RW-1:0] cmd_reg,
    output logic              cmd_rd,
    input  logic [PHY_DW-1:0] cmd_rdata,
    input  logic              cmd_idle,
    output logic              done,
    output logic              phy_found,
    output logic              phy_missing,
    output logic              mdio_timeout,
    output logic [PHY_AW-1:0] phy_addr
);
    sq_state_t    state_q;
    scan_result_t res_q;
    logic         done_q;

    logic         launch;
    logic         waiting;
    logic         expire;
    logic         resp;
    logic         accept;
    logic         last_probe;
    logic         advance;
    logic         finish;
    logic [PHY_AW-1:0] probe_addr;

    assign launch  = start && (state_q == SQ_IDLE);
    assign waiting = (state_q == SQ_PRE) || (state_q == SQ_POST);
    assign resp    = (state_q == SQ_POST) && cmd_idle;
    assign accept  = resp && status_ok(cmd_rdata, CAP_MASK);
    assign advance = resp && !accept && !last_probe;
    assign finish  = expire || accept || (resp && last_probe);

    phy_scan_poll_timer #(.LIMIT(POLL_LIMIT)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .poll   (waiting),
        .idle   (cmd_idle),
        .expire (expire)
    );

    phy_scan_addr_gen u_addr (
        .clk        (clk),
        .rst        (rst),
        .load       (launch),
        .dflt_valid (dflt_valid),
        .dflt_addr  (dflt_addr),
        .advance    (advance),
        .addr       (probe_addr),
        .last_probe (last_probe)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            res_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= finish;
            if (finish) begin
                state_q <= SQ_IDLE;
                res_q   <= '{found:   accept,
                             missing: !accept && !expire,
                             timeout: expire,
                             addr:    accept ? probe_addr : '0};
            end else begin
                unique case (state_q)
                    SQ_IDLE: begin
                        if (launch) begin
                            state_q <= SQ_PRE;
                            res_q   <= '0;
                        end
                    end
                    SQ_PRE:   if (cmd_idle) state_q <= SQ_ISSUE;
                    SQ_ISSUE: state_q <= SQ_POST;
                    SQ_POST:  if (advance) state_q <= SQ_PRE;
                    default:  state_q <= SQ_IDLE;
                endcase
            end
        end
    end

    assign cmd_addr     = probe_addr;
    assign cmd_reg      = STATUS_REG;
    assign cmd_rd       = (state_q == SQ_ISSUE);
    assign done         = done_q;
    assign phy_found    = res_q.found;
    assign phy_missing  = res_q.missing;
    assign mdio_timeout = res_q.timeout;
    assign phy_addr     = res_q.addr;
endmodule

// File: rtl/phy_scan_seq_chk.sv
module phy_scan_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       cmd_idle,
    input logic       cmd_rd,
    input logic       done,
    input logic       phy_found,
    input logic       phy_missing,
    input logic       mdio_timeout,
    input logic [4:0] phy_addr
);
    a_r2_strobe_after_idle: assert property (@(posedge clk) disable iff (rst)
        cmd_rd |-> $past(cmd_idle));

    a_r2_strobe_single: assert property (@(posedge clk) disable iff (rst)
        cmd_rd |=> !cmd_rd);

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r8_one_flag: assert property (@(posedge clk) disable iff (rst)
        done |-> $onehot({phy_found, phy_missing, mdio_timeout}));

    a_r8_result_hold: assert property (@(posedge clk) disable iff (rst)
        (phy_found && !start) |=> (phy_found && $stable(phy_addr)));

    a_r6_missing_with_done: assert property (@(posedge clk) disable iff (rst)
        $rose(phy_missing) |-> done);

    a_r7_timeout_with_done: assert property (@(posedge clk) disable iff (rst)
        $rose(mdio_timeout) |-> done);
endmodule

bind phy_scan_seq phy_scan_seq_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .cmd_idle     (cmd_idle),
    .cmd_rd       (cmd_rd),
    .done         (done),
    .phy_found    (phy_found),
    .phy_missing  (phy_missing),
    .mdio_timeout (mdio_timeout),
    .phy_addr     (phy_addr)
);

// File: tb/phy_scan_seq_tb.sv
module phy_scan_seq_tb;
    localparam int LAT = 3;

    typedef struct {
        bit       found;
        bit       missing;
        bit       tmo;
        bit [4:0] addr;
        int       lat;
    } exp_t;

    typedef struct {
        bit [4:0] addr;
        string    tag;
    } probe_t;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic        dflt_valid;
    logic [4:0]  dflt_addr;
    logic [4:0]  cmd_addr;
    logic [4:0]  cmd_reg;
    logic        cmd_rd;
    logic [15:0] cmd_rdata;
    logic        cmd_idle;
    logic        done;
    logic        phy_found;
    logic        phy_missing;
    logic        mdio_timeout;
    logic [4:0]  phy_addr;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int stamp  = 0;

    exp_t   exp_q[$];
    probe_t probe_q[$];

    logic [15:0] tab [32];
    bit          hang_pre  = 1'b0;
    bit          hang_post = 1'b0;
    int          busy;
    logic [4:0]  lat_addr;
    bit          prev_done = 1'b0;

    always #2.5 clk = ~clk;

    phy_scan_seq u_dut (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .dflt_valid   (dflt_valid),
        .dflt_addr    (dflt_addr),
        .cmd_addr     (cmd_addr),
        .cmd_reg      (cmd_reg),
        .cmd_rd       (cmd_rd),
        .cmd_rdata    (cmd_rdata),
        .cmd_idle     (cmd_idle),
        .done         (done),
        .phy_found    (phy_found),
        .phy_missing  (phy_missing),
        .mdio_timeout (mdio_timeout),
        .phy_addr     (phy_addr)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic bit phy_ok(input logic [15:0] v);
        return (v != 16'hFFFF) && v[12] && v[11] && v[3];
    endfunction

    // MDIO engine model
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            cmd_idle  <= 1'b1;
            cmd_rdata <= 16'h0;
            busy      <= 0;
        end else if (hang_pre) begin
            cmd_idle <= 1'b0;
        end else if (cmd_rd) begin
            cmd_idle <= 1'b0;
            busy     <= LAT;
            lat_addr <= cmd_addr;
        end else if (busy == 1) begin
            busy <= 0;
            if (!hang_post) begin
                cmd_idle  <= 1'b1;
                cmd_rdata <= tab[lat_addr];
            end
        end else if (busy > 1) begin
            busy <= busy - 1;
        end
    end

    // monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_done) check(done == 1'b0, "R8 done one cycle", int'(done), 0);
            prev_done = done;
            if (cmd_rd) begin
                check(cmd_reg == 5'd1, "R2 register number", int'(cmd_reg), 1);
                if (probe_q.size() == 0) begin
                    check(1'b0, "R5 unexpected extra probe", int'(cmd_addr), -1);
                end else begin
                    probe_t p;
                    p = probe_q.pop_front();
                    check(cmd_addr == p.addr, p.tag, int'(cmd_addr), int'(p.addr));
                end
            end
            if (done) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(phy_found == e.found, "R3 found flag", int'(phy_found), int'(e.found));
                    check(phy_missing == e.missing, "R6 missing flag", int'(phy_missing), int'(e.missing));
                    check(mdio_timeout == e.tmo, "R7 timeout flag", int'(mdio_timeout), int'(e.tmo));
                    check(phy_addr == e.addr, "R5 result address", int'(phy_addr), int'(e.addr));
                    check(cyc - stamp == e.lat, "R9 done timing", cyc - stamp, e.lat);
                end
            end
        end else begin
            prev_done = 1'b0;
        end
    end

    task automatic clear_tab();
        for (int i = 0; i < 32; i++) tab[i] = 16'hFFFF;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        hang_pre = 1'b0;
        hang_post = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    // mode: 0 normal, 1 engine stuck before command, 2 stuck after command
    task automatic run_case(input bit dv, input bit [4:0] da, input int mode, input bit mid_start);
        exp_t e;
        int   n = 0;
        bit   hit = 1'b0;
        e = '{found: 1'b0, missing: 1'b0, tmo: 1'b0, addr: 5'd0, lat: 0};
        if (mode == 1) begin
            e.tmo = 1'b1;
            e.lat = 201;
        end else if (mode == 2) begin
            probe_q.push_back('{addr: dv ? da : 5'd31, tag: "R4 first probe address"});
            e.tmo = 1'b1;
            e.lat = 203;
        end else begin
            if (dv) begin
                probe_q.push_back('{addr: da, tag: "R4 preferred address first"});
                n++;
                if (phy_ok(tab[da])) begin
                    hit = 1'b1;
                    e.addr = da;
                end
            end
            for (int a = 31; a >= 0 && !hit; a--) begin
                probe_q.push_back('{addr: 5'(a), tag: "R5 descending scan order"});
                n++;
                if (phy_ok(tab[a])) begin
                    hit = 1'b1;
                    e.addr = 5'(a);
                end
            end
            e.found   = hit;
            e.missing = !hit;
            e.lat     = 1 + n * (LAT + 3);
        end
        exp_q.push_back(e);
        hang_pre  = (mode == 1);
        hang_post = (mode == 2);
        dflt_valid = dv;
        dflt_addr  = da;
        start = 1'b1;
        stamp = cyc;
        @(negedge clk);
        start = 1'b0;
        if (mid_start) begin
            repeat (15) @(negedge clk);
            dflt_valid = 1'b1;
            dflt_addr  = 5'd2;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait (exp_q.size() == 0);
        @(negedge clk);
        check(probe_q.size() == 0, "R5 no probe after stop", probe_q.size(), 0);
        probe_q.delete();
    endtask

    initial begin
        start = 1'b0;
        dflt_valid = 1'b0;
        dflt_addr = 5'd0;
        clear_tab();
        rst = 1'b1;
        @(negedge clk);
        check(done == 1'b0 && cmd_rd == 1'b0, "R1 reset strobes", int'(done), 0);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check({phy_found, phy_missing, mdio_timeout} == 3'b000, "R1 reset flags",
              int'({phy_found, phy_missing, mdio_timeout}), 0);
        check(phy_addr == 5'd0, "R1 reset address", int'(phy_addr), 0);

        // R4: preferred address passes at once
        tab[9] = 16'h7849;
        run_case(1'b1, 5'd9, 0, 1'b0);
        repeat (5) @(negedge clk);
        check(phy_found == 1'b1 && phy_addr == 5'd9, "R8 result held", int'(phy_addr), 9);

        // R5: preferred address empty, scan finds 9
        run_case(1'b1, 5'd5, 0, 1'b0);

        // R3: rejected near-misses before an accepted value
        clear_tab();
        tab[28] = 16'hFFFF;
        tab[25] = 16'h1800;
        tab[22] = 16'h1008;
        tab[20] = 16'h1808;
        run_case(1'b0, 5'd0, 0, 1'b0);

        // R5: only address 0 passes
        clear_tab();
        tab[3] = 16'h0808;
        tab[0] = 16'h180C;
        run_case(1'b0, 5'd0, 0, 1'b0);

        // R6: nothing present, preferred address also empty
        clear_tab();
        run_case(1'b1, 5'd7, 0, 1'b0);

        // R5: address 31 answers first
        tab[31] = 16'h1808;
        run_case(1'b0, 5'd0, 0, 1'b0);

        // R9: start while busy is ignored
        clear_tab();
        tab[2]  = 16'h1808;
        tab[17] = 16'hF80F;
        run_case(1'b0, 5'd0, 0, 1'b1);

        // R7: engine never idle before the command
        run_case(1'b0, 5'd0, 1, 1'b0);
        do_reset();
        check(mdio_timeout == 1'b0, "R1 flags cleared by reset", int'(mdio_timeout), 0);

        // R7: engine hangs after the first strobe
        run_case(1'b1, 5'd12, 2, 1'b0);
        do_reset();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule